// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a bus-mapped watchdog for a system controller. It has two cascaded down-counters. The first counter's expiry can raise an interrupt, so software gets a warning. If software still does not service the watchdog, the second counter runs out. That expiry drives a reset request and records a sticky timeout flag. Both counters are driven by a tick from a prescaler, which divides the bus clock by a large factor for normal use or by a small factor for quick operation.

The preload registers and the service command are guarded. Before each guarded write, software must write two key values in turn to the service register. The pair opens a window for one guarded write only. A lock bit can pin the watchdog on, so that nothing but power-on reset can turn it off.

Software programs a timeout in seconds, shifted left by 9, into both preloads. Each stage then lasts 512 slow ticks per second. The two stages together take one second per programmed unit.

Top module: `wdt_two_stage`

## Requirements
- R1: Writing 0x80 and then 0x86 (low 16 bits) to the service register at offset 0x0C opens a window. The window allows exactly one guarded write, after which it closes. The guarded writes are a write to a preload (0x00 stage 1, 0x04 stage 2) and a command write to 0x0C. Writing 0x80 again while the first key is pending keeps the sequence armed.
- R2: A preload write without an open window is ignored. A write to 0x0C that is neither the expected key nor a granted command cancels any partial unlock.
- R3: Each preload register holds 20 bits. Read bits above bit 19 return 0.
- R4: A granted command with bit 8 set restarts stage 1 from its preload and clears the prescaler phase. Issuing it often enough keeps both expiries from happening.
- R5: Each stage lasts max(P,1) ticks, where P is that stage's preload. A tick occurs every 2^5 clocks when config bit 2 is 1, and every 2^15 clocks when it is 0.
- R6: Stage-1 expiry sets bit 0 of the interrupt status register at offset 0x08. Writing 1 to that bit clears it. `irq_o` follows the status bit unless config bits 1:0 are 11. The config register at offset 0x10 reads back bits 5, 2 and 1:0, and all other bits read 0.
- R7: Stage-2 expiry in watchdog mode (lock register bit 2 = 0) sets the timeout flag, which reads at bit 9 of 0x0C. If config bit 5 is 0, the expiry also drives `wdt_reset_o` high for exactly 16 cycles. If config bit 5 is 1, there is no pulse. Counting then resumes at stage 1.
- R8: The timeout flag stays set until a granted command with bit 9 set clears it, or until `por_n` goes low.
- R9: The lock register is at offset 0x14, with bit 1 = enable, bit 0 = lock and bit 2 = mode. Once lock is set, lock, mode and enable can no longer be cleared before `por_n`. While disabled, the counters do not advance.
- R10: Changing enable from 0 to 1 restarts stage 1 and the prescaler, as a reload does.
- R11: In free-timer mode (lock register bit 2 = 1), stage-2 expiry sets no flag and produces no reset pulse.
- R12: After `por_n`, all registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is valid after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Stage-1 warning interrupt |
| wdt_reset_o | output | 1 | Stage-2 reset request pulse |

## Verification
The assertions take three things for granted. Each bus access is a one-cycle strobe. Write and read never occur in the same cycle. `por_n` is held low for at least one edge before the first access. The bench drives every access from tasks that raise one strobe at a falling edge and drop it at the next falling edge. Timed checks sample several cycles away from the computed expiry edges, so an error in tick phasing of one cycle lands inside a check window rather than at its margin.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_PRE1 = 8'h00;
   localparam logic [OFS_W-1:0] OFS_PRE2 = 8'h04;
   localparam logic [OFS_W-1:0] OFS_ISTS = 8'h08;
   localparam logic [OFS_W-1:0] OFS_SVC  = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_CFG  = 8'h10;
   localparam logic [OFS_W-1:0] OFS_LOCK = 8'h14;

   localparam int SVC_RELOAD_BIT = 8;
   localparam int SVC_FLAG_BIT   = 9;

   typedef enum logic [1:0] {
      UL_IDLE,
      UL_ARMED,
      UL_OPEN
   } unlock_state_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
   import wdt_pkg::*;
#(
   parameter int KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY_FIRST = 16'h0080,
   parameter logic [KEY_W-1:0] KEY_SECOND = 16'h0086
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_wr,
   input  logic             pre_wr,
   input  logic [KEY_W-1:0] key,
   output logic             grant_svc,
   output logic             grant_pre
);
   unlock_state_e state_q, state_d;

   always_comb begin
      grant_svc = svc_wr && (state_q == UL_OPEN);
      grant_pre = pre_wr && (state_q == UL_OPEN);
      state_d   = state_q;
      if (svc_wr) begin
         if (state_q == UL_OPEN)                        state_d = UL_IDLE;
         else if (key == KEY_FIRST)                     state_d = UL_ARMED;
         else if (state_q == UL_ARMED && key == KEY_SECOND) state_d = UL_OPEN;
         else                                           state_d = UL_IDLE;
      end else if (pre_wr && state_q == UL_OPEN) begin
         state_d = UL_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= UL_IDLE;
      else        state_q <= state_d;
   end

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant_svc, grant_pre}));
   // R1
   single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_svc || grant_pre) |=> !(grant_svc || grant_pre));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int SLOW_LOG2 = 15,
   parameter int FAST_LOG2 = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic fast,
   output logic tick
);
   if (FAST_LOG2 < 1 || FAST_LOG2 >= SLOW_LOG2) begin : g_bad_div
      $error("wdt_prescaler: need 1 <= FAST_LOG2 < SLOW_LOG2");
   end

   logic [SLOW_LOG2-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                phase_q <= '0;
      else if (restart || !run) phase_q <= '0;
      else                      phase_q <= phase_q + 1'b1;
   end

   assign tick = run && !restart &&
                 (fast ? (&phase_q[FAST_LOG2-1:0]) : (&phase_q));

   // R5
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/wdt_stages.sv
module wdt_stages #(
   parameter int CNT_W = 20,
   parameter int PULSE_LEN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] pre1,
   input  logic [CNT_W-1:0] pre2,
   input  logic             wd_mode,
   input  logic             rst_en,
   output logic             exp1,
   output logic             exp2,
   output logic             rst_req
);
   localparam int PW = $clog2(PULSE_LEN + 1);

   logic             stage_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PW-1:0]    pulse_q;
   logic             done;

   assign done = tick && (cnt_q < CNT_W'(2));
   assign exp1 = done && !stage_q;
   assign exp2 = done && stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= 1'b0;
         cnt_q   <= '0;
      end else if (restart || !run) begin
         stage_q <= 1'b0;
         cnt_q   <= pre1;
      end else if (tick) begin
         if (done) begin
            stage_q <= !stage_q;
            cnt_q   <= stage_q ? pre1 : pre2;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pulse_q <= '0;
      else if (exp2 && wd_mode && rst_en) pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0)             pulse_q <= pulse_q - 1'b1;
   end

   assign rst_req = (pulse_q != '0);

   // R7
   pulse_after_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(stage_q));
   // R7
   pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |=> rst_req);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
   import wdt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int PRE_W = 20,
   parameter int SLOW_LOG2 = 15,
   parameter int FAST_LOG2 = 5,
   parameter int PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              wdt_reset_o
);
   localparam int KEY_W = 16;

   if (DATA_W < KEY_W || PRE_W >= DATA_W || ADDR_W != OFS_W) begin : g_bad_width
      $error("wdt_two_stage: unsupported width parameters");
   end

   logic [PRE_W-1:0] pre1_q, pre2_q;
   logic             cfg_rst_dis_q, cfg_fast_q;
   logic [1:0]       cfg_itype_q;
   logic             lock_q, en_q, mode_q, ists_q, flag_q;
   logic             svc_wr, pre1_wr, pre2_wr, grant_svc, grant_pre;
   logic             lock_wr, en_rise, restart, tick, exp1, exp2;
   wire              unused_wdata = ^bus_wdata[DATA_W-1:PRE_W];

   assign svc_wr  = bus_wr && (bus_addr == OFS_SVC);
   assign pre1_wr = bus_wr && (bus_addr == OFS_PRE1);
   assign pre2_wr = bus_wr && (bus_addr == OFS_PRE2);
   assign lock_wr = bus_wr && (bus_addr == OFS_LOCK);
   assign en_rise = lock_wr && !en_q && bus_wdata[1];
   assign restart = en_rise || (grant_svc && bus_wdata[SVC_RELOAD_BIT]);

   wdt_unlock #(.KEY_W(KEY_W), .KEY_FIRST(16'h0080), .KEY_SECOND(16'h0086)) unlock_i (
      .clk(clk), .rst_n(por_n), .svc_wr(svc_wr), .pre_wr(pre1_wr || pre2_wr),
      .key(bus_wdata[KEY_W-1:0]), .grant_svc(grant_svc), .grant_pre(grant_pre));

   wdt_prescaler #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) presc_i (
      .clk(clk), .rst_n(por_n), .run(en_q), .restart(restart),
      .fast(cfg_fast_q), .tick(tick));

   wdt_stages #(.CNT_W(PRE_W), .PULSE_LEN(PULSE_LEN)) stages_i (
      .clk(clk), .rst_n(por_n), .run(en_q), .restart(restart), .tick(tick),
      .pre1(pre1_q), .pre2(pre2_q), .wd_mode(!mode_q), .rst_en(!cfg_rst_dis_q),
      .exp1(exp1), .exp2(exp2), .rst_req(wdt_reset_o));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pre1_q <= '0;  pre2_q <= '0;
         cfg_rst_dis_q <= 1'b0;  cfg_fast_q <= 1'b0;  cfg_itype_q <= 2'b00;
         lock_q <= 1'b0;  en_q <= 1'b0;  mode_q <= 1'b0;
         ists_q <= 1'b0;  flag_q <= 1'b0;
      end else begin
         if (grant_pre && pre1_wr) pre1_q <= bus_wdata[PRE_W-1:0];
         if (grant_pre && pre2_wr) pre2_q <= bus_wdata[PRE_W-1:0];
         if (bus_wr && bus_addr == OFS_CFG) begin
            cfg_rst_dis_q <= bus_wdata[5];
            cfg_fast_q    <= bus_wdata[2];
            cfg_itype_q   <= bus_wdata[1:0];
         end
         if (lock_wr) begin
            en_q   <= bus_wdata[1] || (lock_q && en_q);
            lock_q <= lock_q || bus_wdata[0];
            if (!lock_q) mode_q <= bus_wdata[2];
         end
         if (exp1) ists_q <= 1'b1;
         else if (bus_wr && bus_addr == OFS_ISTS && bus_wdata[0]) ists_q <= 1'b0;
         if (exp2 && !mode_q) flag_q <= 1'b1;
         else if (grant_svc && bus_wdata[SVC_FLAG_BIT]) flag_q <= 1'b0;
      end
   end

   assign irq_o = ists_q && (cfg_itype_q != 2'b11);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) bus_rdata <= '0;
      else if (bus_rd) begin
         unique case (bus_addr)
            OFS_PRE1: bus_rdata <= DATA_W'(pre1_q);
            OFS_PRE2: bus_rdata <= DATA_W'(pre2_q);
            OFS_ISTS: bus_rdata <= DATA_W'(ists_q);
            OFS_SVC:  bus_rdata <= DATA_W'({flag_q, 9'd0});
            OFS_CFG:  bus_rdata <= DATA_W'({cfg_rst_dis_q, 2'b00, cfg_fast_q, cfg_itype_q});
            OFS_LOCK: bus_rdata <= DATA_W'({mode_q, en_q, lock_q});
            default:  bus_rdata <= '0;
         endcase
      end
   end

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q);
   // R9
   locked_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
      (lock_q && en_q) |=> en_q);
   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (flag_q && !grant_svc) |=> flag_q);
   // R2
   preload_guard_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pre1_wr && !grant_pre) |=> $stable(pre1_q));
endmodule

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, wdt_reset_o;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   wdt_two_stage dut_i (
      .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .wdt_reset_o(wdt_reset_o));

   // vector: {is_read, addr, data, expected, requirement number}
   localparam int NV = 28;
   localparam logic [76:0] VEC [NV] = '{
      {1'b1, 8'h00, 32'h0,        32'h0,     4'd12}, // R12
      {1'b1, 8'h14, 32'h0,        32'h0,     4'd12}, // R12
      {1'b0, 8'h00, 32'h123,      32'h0,     4'd2},
      {1'b1, 8'h00, 32'h0,        32'h0,     4'd2},  // R2 unguarded write dropped
      {1'b0, 8'h0C, 32'h80,       32'h0,     4'd1},
      {1'b0, 8'h0C, 32'h86,       32'h0,     4'd1},
      {1'b0, 8'h00, 32'hFFF12345, 32'h0,     4'd3},
      {1'b1, 8'h00, 32'h0,        32'h12345, 4'd3},  // R3 20-bit preload
      {1'b0, 8'h04, 32'h55,       32'h0,     4'd1},
      {1'b1, 8'h04, 32'h0,        32'h0,     4'd1},  // R1 window used up
      {1'b0, 8'h0C, 32'h80,       32'h0,     4'd1},
      {1'b0, 8'h0C, 32'h86,       32'h0,     4'd1},
      {1'b0, 8'h04, 32'h7,        32'h0,     4'd1},
      {1'b1, 8'h04, 32'h0,        32'h7,     4'd1},  // R1 fresh unlock
      {1'b0, 8'h0C, 32'h80,       32'h0,     4'd2},
      {1'b0, 8'h0C, 32'h12,       32'h0,     4'd2},
      {1'b0, 8'h0C, 32'h86,       32'h0,     4'd2},
      {1'b0, 8'h04, 32'h9,        32'h0,     4'd2},
      {1'b1, 8'h04, 32'h0,        32'h7,     4'd2},  // R2 abort
      {1'b0, 8'h0C, 32'h80,       32'h0,     4'd1},
      {1'b0, 8'h0C, 32'h80,       32'h0,     4'd1},
      {1'b0, 8'h0C, 32'h86,       32'h0,     4'd1},
      {1'b0, 8'h04, 32'h9,        32'h0,     4'd1},
      {1'b1, 8'h04, 32'h0,        32'h9,     4'd1},  // R1 repeated first key
      {1'b0, 8'h10, 32'hFFFFFFFF, 32'h0,     4'd6},
      {1'b1, 8'h10, 32'h0,        32'h27,    4'd6},  // R6 config readback
      {1'b0, 8'h10, 32'h0,        32'h0,     4'd8},
      {1'b1, 8'h0C, 32'h0,        32'h0,     4'd8}   // R8 flag clear at start
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic guarded(input logic [7:0] a, input logic [31:0] d);
      wr(8'h0C, 32'h80);
      wr(8'h0C, 32'h86);
      wr(a, d);
   endtask

   task automatic por();
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
   endtask

   task automatic setup(input logic [31:0] p1, input logic [31:0] p2, input logic [31:0] cfg);
      por();
      guarded(8'h00, p1);
      guarded(8'h04, p2);
      wr(8'h10, cfg);
   endtask

   task automatic count_high(input int n, output int irqs, output int rsts);
      irqs = 0; rsts = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (irq_o) irqs++;
         if (wdt_reset_o) rsts++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int ni, nr;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      chk("R12 irq after reset", 32'(irq_o), 0);
      chk("R12 reset out after reset", 32'(wdt_reset_o), 0);
      for (int i = 0; i < NV; i++) begin
         logic [76:0] v;
         v = VEC[i];
         if (v[76]) begin
            rd(v[75:68], d);
            chk($sformatf("R%0d vector %0d", v[3:0], i), d, v[35:4]);
         end else begin
            wr(v[75:68], v[67:36]);
         end
      end

      // R5 R6 R7: fast tick, preloads 2/2, enable edge at E
      setup(2, 2, 32'h4);
      wr(8'h14, 32'h2);
      repeat (60) @(negedge clk);
      chk("R5 irq before stage1 end", 32'(irq_o), 0);
      repeat (10) @(negedge clk);
      chk("R6 irq after stage1 end", 32'(irq_o), 1);
      wr(8'h10, 32'h7);
      chk("R6 irq masked by type 11", 32'(irq_o), 0);
      wr(8'h10, 32'h4);
      chk("R6 irq unmasked", 32'(irq_o), 1);
      wr(8'h08, 32'h1);
      chk("R6 status cleared", 32'(irq_o), 0);
      count_high(90, ni, nr);
      chk("R7 reset pulse length", nr, 16);
      rd(8'h0C, d);
      chk("R7 timeout flag set", d, 32'h200);
      // R8
      wr(8'h0C, 32'h200);
      rd(8'h0C, d);
      chk("R8 flag kept without unlock", d, 32'h200);
      guarded(8'h0C, 32'h200);
      rd(8'h0C, d);
      chk("R8 flag cleared by guarded write", d, 32'h0);

      // R4: periodic service prevents both expiries
      setup(3, 3, 32'h4);
      wr(8'h14, 32'h2);
      ni = 0; nr = 0;
      for (int k = 0; k < 8; k++) begin
         int a, b;
         count_high(50, a, b);
         ni += a; nr += b;
         guarded(8'h0C, 32'h100);
      end
      chk("R4 no irq while serviced", ni, 0);
      chk("R4 no reset while serviced", nr, 0);

      // R7: reset output disabled by config bit 5
      setup(1, 1, 32'h24);
      wr(8'h14, 32'h2);
      count_high(100, ni, nr);
      chk("R7 no pulse with bit5 set", nr, 0);
      rd(8'h0C, d);
      chk("R7 flag still set with bit5 set", d, 32'h200);

      // R11: free-timer mode
      setup(1, 1, 32'h4);
      wr(8'h14, 32'h6);
      count_high(100, ni, nr);
      chk("R11 no pulse in timer mode", nr, 0);
      chk("R11 stage1 still runs", 32'(ni > 0), 1);
      rd(8'h0C, d);
      chk("R11 no flag in timer mode", d, 32'h0);
      rd(8'h14, d);
      chk("R11 mode readback", d, 32'h6);

      // R9: lock pins enable; disabled counters hold
      setup(1, 1, 32'h4);
      count_high(100, ni, nr);
      chk("R9 disabled raises no irq", ni, 0);
      wr(8'h14, 32'h3);
      wr(8'h14, 32'h0);
      rd(8'h14, d);
      chk("R9 lock and enable stay set", d, 32'h3);

      // R10: re-enable restarts stage 1
      setup(2, 2, 32'h4);
      wr(8'h14, 32'h2);
      repeat (50) @(negedge clk);
      wr(8'h14, 32'h0);
      repeat (20) @(negedge clk);
      wr(8'h14, 32'h2);
      repeat (60) @(negedge clk);
      chk("R10 no irq before full restart", 32'(irq_o), 0);
      repeat (10) @(negedge clk);
      chk("R10 irq after full stage", 32'(irq_o), 1);

      // R5: slow tick, 2^15 clocks
      setup(1, 1, 32'h0);
      wr(8'h14, 32'h2);
      repeat (32760) @(negedge clk);
      chk("R5 slow irq not yet", 32'(irq_o), 0);
      repeat (20) @(negedge clk);
      chk("R5 slow irq after 2^15", 32'(irq_o), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule